// File: doc/BRIEF.md
# Mode-Coded Address Generation Unit

This block produces the operand effective address for a register-indirect addressing scheme and performs the matching pointer write-back. It keeps a bank of address pointers and a bank of offset registers of equal size; pointer i is always paired with offset i. Each request names a pointer through a 3-bit register select and names an update rule through a 3-bit mode code. The effective address appears in the same cycle as the request, through combinational logic. The pointer write-back is committed at the next rising clock edge.

One mode code does not use a pointer at all. It marks an operand carried in an extension word, either immediate data or an absolute address. In that case the block passes the extension word through and raises a flag that tells which kind of operand it is. Two dedicated load ports write the pointer and offset banks directly. All arithmetic is linear and wraps modulo 2^ADDR_W.

Top module: `agu_core`

## Requirements
- R1: A synchronous active-low reset clears every pointer and every offset register to zero.
- R2: Mode 3'b100 gives the selected pointer Rn as the effective address and leaves Rn unchanged.
- R3: Mode 3'b011 gives Rn as the address and writes Rn+1 back. Mode 3'b010 gives Rn as the address and writes Rn-1 back.
- R4: Mode 3'b001 gives Rn as the address and writes Rn+Nn back, where Nn is the offset register with the same index. Mode 3'b000 gives Rn and writes Rn-Nn back.
- R5: Mode 3'b101 gives Rn+Nn as the address and leaves Rn unchanged.
- R6: Mode 3'b111 gives Rn-1 as the address and writes that same value back to Rn.
- R7: Mode 3'b110 with register code 3'b100 raises `imm_hit`. With register code 3'b000 it raises `abs_hit`. In both cases `ea` equals `ext_word` and no pointer changes.
- R8: Mode 3'b110 with any other register code raises `illegal_mode`, holds `ea_valid` low, drives `ea` to zero and changes no pointer.
- R9: Address arithmetic is ADDR_W-bit two's complement and wraps: all-ones plus 1 gives 0, and 0 minus 1 gives all-ones.
- R10: A pointer load on `ald_*` writes the pointer at the next edge. If it targets the pointer that a request updates in the same cycle, the loaded value wins. An offset load on `old_*` writes the offset register at the next edge.
- R11: With `req_valid` low, `ea_valid`, `imm_hit`, `abs_hit` and `illegal_mode` stay low, and no pointer is updated by the mode fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An address request is present this cycle |
| req_mode | input | 3 | Update-rule code |
| req_reg | input | 3 | Pointer/offset index, or the operand kind in the special mode |
| ext_word | input | ADDR_W | Extension word for immediate or absolute operands |
| ald_en | input | 1 | Pointer load strobe |
| ald_sel | input | 3 | Pointer load index |
| ald_data | input | ADDR_W | Pointer load value |
| old_en | input | 1 | Offset load strobe |
| old_sel | input | 3 | Offset load index |
| old_data | input | ADDR_W | Offset load value |
| ea | output | ADDR_W | Effective address or immediate operand |
| ea_valid | output | 1 | A legal request is served this cycle |
| imm_hit | output | 1 | The operand is immediate data from `ext_word` |
| abs_hit | output | 1 | The operand is an absolute address from `ext_word` |
| illegal_mode | output | 1 | Special mode with an undefined register code |

## Verification
A corrupted pointer or offset does not show at the ports until the next request reads that index. The next `ea` for that index, or the address after it, then differs from the bench model. For this reason the bench issues plain no-update reads of all eight pointers after each directed phase and at the end of the random phase. A wrong update rule shows one cycle after the faulty request, as soon as the same index is read again. Decode faults in the special group show at once on the three flags and on `ea`.

// File: rtl/agu_pkg.sv
// Package: shared mode codes and the decoded control word of the address unit.
// Assumes a fixed 3-bit mode field and a 3-bit register/kind field.
package agu_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_POST_SUB_OFF = 3'b000,
        MODE_POST_ADD_OFF = 3'b001,
        MODE_POST_DEC     = 3'b010,
        MODE_POST_INC     = 3'b011,
        MODE_PLAIN        = 3'b100,
        MODE_INDEXED      = 3'b101,
        MODE_SPECIAL      = 3'b110,
        MODE_PRE_DEC      = 3'b111
    } agu_mode_e;

    localparam logic [MODE_W-1:0] KIND_IMM = 3'b100;
    localparam logic [MODE_W-1:0] KIND_ABS = 3'b000;

    typedef struct packed {
        logic ea_valid;   // legal request served
        logic wb_en;      // write sum back to the pointer
        logic use_sum;    // effective address is the sum, not the raw pointer
        logic use_off;    // delta is the offset register, else one
        logic sub;        // subtract delta instead of adding
        logic take_ext;   // effective address is the extension word
        logic is_imm;     // immediate operand flag
        logic is_abs;     // absolute address flag
        logic illegal;    // undefined special code
    } agu_ctl_t;

endpackage

// File: rtl/agu_regfile.sv
// Module: pointer and offset register banks.
// Holds NREG pointers and NREG offsets. A direct pointer load takes priority
// over a mode write-back to the same index. Both banks have one combinational
// read port, addressed by the request select.
// Assumes the select widths cover NREG.
module agu_regfile #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 8,
    parameter int SEL_W  = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SEL_W-1:0]          rd_sel,
    output logic [ADDR_W-1:0]         rd_addr,
    output logic [ADDR_W-1:0]         rd_off,
    input  logic                      upd_en,
    input  logic [SEL_W-1:0]          upd_sel,
    input  logic [ADDR_W-1:0]         upd_data,
    input  logic                      ald_en,
    input  logic [SEL_W-1:0]          ald_sel,
    input  logic [ADDR_W-1:0]         ald_data,
    input  logic                      old_en,
    input  logic [SEL_W-1:0]          old_sel,
    input  logic [ADDR_W-1:0]         old_data,
    output logic [NREG-1:0][ADDR_W-1:0] addr_all
);

    logic [ADDR_W-1:0] addr_q [NREG];
    logic [ADDR_W-1:0] off_q  [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_bank
        // Pointer register: reset, then direct load beats mode write-back.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q[g] <= '0;
            end else if (ald_en && (ald_sel == SEL_W'(g))) begin
                addr_q[g] <= ald_data;
            end else if (upd_en && (upd_sel == SEL_W'(g))) begin
                addr_q[g] <= upd_data;
            end
        end

        // Offset register: reset, then direct load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                off_q[g] <= '0;
            end else if (old_en && (old_sel == SEL_W'(g))) begin
                off_q[g] <= old_data;
            end
        end

        // Flattened pointer view for observation by the checker.
        assign addr_all[g] = addr_q[g];
    end

    // Combinational read of the pair selected by the request.
    always_comb begin
        rd_addr = addr_q[rd_sel];
        rd_off  = off_q[rd_sel];
    end

endmodule

// File: rtl/agu_mode_decode.sv
// Module: mode decoder.
// Turns the request valid, mode code and register/kind code into the control
// word that steers the arithmetic and the write-back. Purely combinational.
// Assumes the mode encoding from agu_pkg.
module agu_mode_decode
    import agu_pkg::*;
(
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [MODE_W-1:0] req_reg,
    output agu_ctl_t          ctl
);

    // Map each mode to its arithmetic and write-back controls.
    always_comb begin
        ctl = '0;
        if (req_valid) begin
            ctl.ea_valid = 1'b1;
            unique case (agu_mode_e'(req_mode))
                MODE_PLAIN: begin
                end
                MODE_POST_INC: begin
                    ctl.wb_en = 1'b1;
                end
                MODE_POST_DEC: begin
                    ctl.wb_en = 1'b1;
                    ctl.sub   = 1'b1;
                end
                MODE_POST_ADD_OFF: begin
                    ctl.wb_en   = 1'b1;
                    ctl.use_off = 1'b1;
                end
                MODE_POST_SUB_OFF: begin
                    ctl.wb_en   = 1'b1;
                    ctl.use_off = 1'b1;
                    ctl.sub     = 1'b1;
                end
                MODE_INDEXED: begin
                    ctl.use_sum = 1'b1;
                    ctl.use_off = 1'b1;
                end
                MODE_PRE_DEC: begin
                    ctl.wb_en   = 1'b1;
                    ctl.use_sum = 1'b1;
                    ctl.sub     = 1'b1;
                end
                MODE_SPECIAL: begin
                    if (req_reg == KIND_IMM) begin
                        ctl.take_ext = 1'b1;
                        ctl.is_imm   = 1'b1;
                    end else if (req_reg == KIND_ABS) begin
                        ctl.take_ext = 1'b1;
                        ctl.is_abs   = 1'b1;
                    end else begin
                        ctl.illegal  = 1'b1;
                        ctl.ea_valid = 1'b0;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/agu_arith.sv
// Module: linear address arithmetic.
// Forms pointer +/- (1 or offset) with wrap-around, then chooses the
// effective address from the raw pointer, that sum, or the extension word.
// Assumes ctl comes from agu_mode_decode. An illegal request yields zero.
module agu_arith
    import agu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  agu_ctl_t          ctl,
    input  logic [ADDR_W-1:0] rn,
    input  logic [ADDR_W-1:0] nn,
    input  logic [ADDR_W-1:0] ext_word,
    output logic [ADDR_W-1:0] sum,
    output logic [ADDR_W-1:0] ea
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] delta;

    // Adder/subtractor shared by every pointer-based mode.
    always_comb begin
        delta = ctl.use_off ? nn : ONE;
        sum   = ctl.sub ? (rn - delta) : (rn + delta);
    end

    // Effective address selection.
    always_comb begin
        if (ctl.illegal) begin
            ea = '0;
        end else if (ctl.take_ext) begin
            ea = ext_word;
        end else if (ctl.use_sum) begin
            ea = sum;
        end else begin
            ea = rn;
        end
    end

endmodule

// File: rtl/agu_core.sv
// Module: address generation unit top.
// Serves one request per cycle: the effective address is combinational from
// the current registers, and the write-back lands at the next rising edge.
// Assumes synchronous active-low reset and NREG a power of two (8 by default).
module agu_core
    import agu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_mode,
    input  logic [2:0]        req_reg,
    input  logic [ADDR_W-1:0] ext_word,
    input  logic              ald_en,
    input  logic [2:0]        ald_sel,
    input  logic [ADDR_W-1:0] ald_data,
    input  logic              old_en,
    input  logic [2:0]        old_sel,
    input  logic [ADDR_W-1:0] old_data,
    output logic [ADDR_W-1:0] ea,
    output logic              ea_valid,
    output logic              imm_hit,
    output logic              abs_hit,
    output logic              illegal_mode
);

    localparam int SEL_W = $clog2(NREG);

    agu_ctl_t                  ctl;
    logic [ADDR_W-1:0]         rn;
    logic [ADDR_W-1:0]         nn;
    logic [ADDR_W-1:0]         sum;
    logic [NREG-1:0][ADDR_W-1:0] addr_all;

    agu_mode_decode u_dec (
        .req_valid (req_valid),
        .req_mode  (req_mode),
        .req_reg   (req_reg),
        .ctl       (ctl)
    );

    agu_regfile #(
        .ADDR_W (ADDR_W),
        .NREG   (NREG),
        .SEL_W  (SEL_W)
    ) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel   (SEL_W'(req_reg)),
        .rd_addr  (rn),
        .rd_off   (nn),
        .upd_en   (ctl.wb_en),
        .upd_sel  (SEL_W'(req_reg)),
        .upd_data (sum),
        .ald_en   (ald_en),
        .ald_sel  (SEL_W'(ald_sel)),
        .ald_data (ald_data),
        .old_en   (old_en),
        .old_sel  (SEL_W'(old_sel)),
        .old_data (old_data),
        .addr_all (addr_all)
    );

    agu_arith #(
        .ADDR_W (ADDR_W)
    ) u_ar (
        .ctl      (ctl),
        .rn       (rn),
        .nn       (nn),
        .ext_word (ext_word),
        .sum      (sum),
        .ea       (ea)
    );

    // Status outputs straight from the decoded control word.
    always_comb begin
        ea_valid     = ctl.ea_valid;
        imm_hit      = ctl.is_imm;
        abs_hit      = ctl.is_abs;
        illegal_mode = ctl.illegal;
    end

endmodule

// File: rtl/agu_core_chk.sv
// Module: protocol and state checker for agu_core, attached by bind.
// Relates request ports to the pointer bank one edge later.
module agu_core_chk #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic [2:0]                  req_mode,
    input logic [2:0]                  req_reg,
    input logic [ADDR_W-1:0]           ext_word,
    input logic                        ald_en,
    input logic [2:0]                  ald_sel,
    input logic [ADDR_W-1:0]           ald_data,
    input logic [ADDR_W-1:0]           ea,
    input logic                        ea_valid,
    input logic                        imm_hit,
    input logic                        abs_hit,
    input logic                        illegal_mode,
    input logic [NREG-1:0][ADDR_W-1:0] addr_all
);

    logic clash;
    assign clash = ald_en && (ald_sel == req_reg);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> addr_all == '0);

    assert_hold_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_mode == 3'b100 || req_mode == 3'b101) && !clash)
        |=> addr_all[$past(req_reg)] == $past(addr_all[req_reg]));

    assert_post_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 3'b011 && !clash)
        |=> addr_all[$past(req_reg)] == $past(ea) + ADDR_W'(1));

    assert_pre_dec_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 3'b111 && !clash)
        |=> addr_all[$past(req_reg)] == $past(ea));

    assert_ext_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_hit || abs_hit) |-> (ea == ext_word && ea_valid));

    assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({imm_hit, abs_hit, illegal_mode}));

    assert_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_mode |-> (req_valid && req_mode == 3'b110 && !ea_valid && ea == '0));

    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ald_en |=> addr_all[$past(ald_sel)] == $past(ald_data));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(ea_valid || imm_hit || abs_hit || illegal_mode));

endmodule

bind agu_core agu_core_chk #(
    .ADDR_W (ADDR_W),
    .NREG   (NREG)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_mode     (req_mode),
    .req_reg      (req_reg),
    .ext_word     (ext_word),
    .ald_en       (ald_en),
    .ald_sel      (ald_sel),
    .ald_data     (ald_data),
    .ea           (ea),
    .ea_valid     (ea_valid),
    .imm_hit      (imm_hit),
    .abs_hit      (abs_hit),
    .illegal_mode (illegal_mode),
    .addr_all     (addr_all)
);

// File: tb/test_agu_core.sv
`timescale 1ns/1ps
module test_agu_core;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [2:0]   req_mode = '0;
    logic [2:0]   req_reg = '0;
    logic [W-1:0] ext_word = '0;
    logic         ald_en = 1'b0;
    logic [2:0]   ald_sel = '0;
    logic [W-1:0] ald_data = '0;
    logic         old_en = 1'b0;
    logic [2:0]   old_sel = '0;
    logic [W-1:0] old_data = '0;
    logic [W-1:0] ea;
    logic         ea_valid, imm_hit, abs_hit, illegal_mode;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [W-1:0] m_a [8];
    logic [W-1:0] m_n [8];

    always #2 clk = ~clk;

    agu_core #(.ADDR_W(W), .NREG(8)) i_agu_core (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_reg(req_reg), .ext_word(ext_word), .ald_en(ald_en), .ald_sel(ald_sel),
        .ald_data(ald_data), .old_en(old_en), .old_sel(old_sel), .old_data(old_data),
        .ea(ea), .ea_valid(ea_valid), .imm_hit(imm_hit), .abs_hit(abs_hit),
        .illegal_mode(illegal_mode)
    );

    function automatic string tag_of(logic [2:0] m);
        case (m)
            3'b100: return "R2";
            3'b011, 3'b010: return "R3";
            3'b001, 3'b000: return "R4";
            3'b101: return "R5";
            3'b111: return "R6";
            default: return "R7/R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: compare at the falling edge, advance the model, cross the edge.
    task automatic cyc(input string tag);
        logic [W-1:0] r, n, e_ea, wb;
        bit e_v, e_imm, e_abs, e_ill, e_wb;
        @(negedge clk);
        r = m_a[req_reg]; n = m_n[req_reg];
        e_ea = r; wb = r; e_wb = 0;
        e_imm = 0; e_abs = 0; e_ill = 0; e_v = req_valid;
        case (req_mode)
            3'b011: begin wb = r + 1; e_wb = 1; end
            3'b010: begin wb = r - 1; e_wb = 1; end
            3'b001: begin wb = r + n; e_wb = 1; end
            3'b000: begin wb = r - n; e_wb = 1; end
            3'b101: e_ea = r + n;
            3'b111: begin e_ea = r - 1; wb = r - 1; e_wb = 1; end
            3'b110: begin
                if (req_reg == 3'b100) begin e_imm = 1; e_ea = ext_word; end
                else if (req_reg == 3'b000) begin e_abs = 1; e_ea = ext_word; end
                else begin e_ill = 1; e_ea = '0; e_v = 0; end
            end
            default: ;
        endcase
        if (!req_valid) begin
            e_imm = 0; e_abs = 0; e_ill = 0; e_wb = 0;
        end
        chk(ea_valid == e_v, {tag, " ea_valid"}, W'(ea_valid), W'(e_v));
        chk(imm_hit == e_imm, {tag, " imm_hit"}, W'(imm_hit), W'(e_imm));
        chk(abs_hit == e_abs, {tag, " abs_hit"}, W'(abs_hit), W'(e_abs));
        chk(illegal_mode == e_ill, {tag, " illegal_mode"}, W'(illegal_mode), W'(e_ill));
        if (e_v || e_ill) chk(ea == e_ea, {tag, " ea"}, ea, e_ea);
        if (e_wb) m_a[req_reg] = wb;
        if (ald_en) m_a[ald_sel] = ald_data;
        if (old_en) m_n[old_sel] = old_data;
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        req_valid = 0; ald_en = 0; old_en = 0;
    endtask

    task automatic req(input logic [2:0] m, input logic [2:0] r, input string tag);
        quiet(); req_valid = 1; req_mode = m; req_reg = r;
        cyc(tag);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 8; i++) req(3'b100, 3'(i), tag);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_a[i] = '0; m_n[i] = '0; end
        void'($urandom(32'h5eed_0a61));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        read_all("R1 reset");

        // Load pointers and offsets together.
        for (int i = 0; i < 8; i++) begin
            quiet(); ald_en = 1; ald_sel = 3'(i); ald_data = 32'h1000 * (i + 1);
            old_en = 1; old_sel = 3'(i); old_data = W'(i * 4 + 3);
            cyc("R10 load");
        end
        req(3'b011, 0, "R3 post-inc"); req(3'b010, 1, "R3 post-dec");
        req(3'b001, 2, "R4 post-add");  req(3'b000, 3, "R4 post-sub");
        req(3'b101, 4, "R5 indexed");   req(3'b111, 5, "R6 pre-dec");
        req(3'b111, 5, "R6 pre-dec again");
        ext_word = 32'hCAFE_0001; req(3'b110, 3'b100, "R7 immediate");
        ext_word = 32'h0BAD_F00D; req(3'b110, 3'b000, "R7 absolute");
        for (int k = 1; k < 8; k++) if (k != 4) req(3'b110, 3'(k), "R8 illegal");
        quiet(); req_mode = 3'b011; req_reg = 6; cyc("R11 idle");
        read_all("R2 after directed");

        // Wrap corners.
        quiet(); ald_en = 1; ald_sel = 7; ald_data = '1; cyc("R9 load");
        req(3'b011, 7, "R9 inc wrap");
        req(3'b100, 7, "R9 read zero");
        req(3'b010, 7, "R9 dec wrap");
        req(3'b100, 7, "R9 read ones");
        // Load beats write-back on the same pointer.
        quiet(); req_valid = 1; req_mode = 3'b001; req_reg = 2;
        ald_en = 1; ald_sel = 2; ald_data = 32'h7777_0000; cyc("R10 clash");
        req(3'b100, 2, "R10 clash read");

        // Random phase.
        for (int t = 0; t < 3000; t++) begin
            req_valid = ($urandom % 4) != 0;
            req_mode  = 3'($urandom);
            req_reg   = 3'($urandom);
            ext_word  = $urandom;
            ald_en    = ($urandom % 5) == 0;
            ald_sel   = 3'($urandom);
            ald_data  = ($urandom % 8 == 0) ? '1 : $urandom;
            old_en    = ($urandom % 6) == 0;
            old_sel   = 3'($urandom);
            old_data  = $urandom;
            cyc(req_valid ? tag_of(req_mode) : "R11");
        end
        read_all("R2 final");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule